// File: doc/BRIEF.md
# Serial NVRAM Checksum Engine

This engine computes a 16-bit checksum over a run of bytes held in a byte-wide memory, then stores the result back into that memory. A host gives it a first address, a byte count and a destination address, and raises a start strobe. The engine reads the memory one byte per cycle, folds each overlapping big-endian word into a running 16-bit value with a nibble-based update, and writes the finished value as two bytes, high byte first.

The update starts from all ones. For a count `n`, let `m` be `n` with bit 0 cleared. For each index `i` with `0 <= i < m`, the word `{mem[a+i], mem[a+i+1]}` is folded in. Each word shares one byte with the word before it. If `n` is odd, one more fold uses `{mem[a+m], 8'h00}`. The fold on value `c` and word `w` takes `x = c ^ w`, `p = x[3:0]` and `q = x[7:4] ^ p`. The new value is `(c >> 8) ^ (p << 3) ^ (p << 8) ^ q ^ (q << 7) ^ (q << 12)`, kept to 16 bits. A typical parameter block is covered from offset 0 with count 0xF8, and the result is stored at offset 0xFC.

The memory port is synchronous. A read issued in one cycle returns its data in the next cycle. The same address bus carries writes.

Top module: `nvcrc_engine`

## Requirements
- R1: While reset is asserted and right after it is released, `busy_o`, `done_o`, `mem_rd_en_o` and `mem_wr_en_o` are all 0.
- R2: The running value starts at 0xFFFF, and every fold follows the nibble update given above, kept to 16 bits.
- R3: For count `n > 0` and `m = n & ~1`, the words folded are `{mem[a+i], mem[a+i+1]}` for `i = 0 .. m-1`, in that order. The byte at the lower address is the upper 8 bits of the word.
- R4: When `n` is odd, a last fold uses the byte at `a+m` as the upper 8 bits and zero as the lower 8 bits.
- R5: A count of 0 issues no reads and writes 0xFF to the destination and 0xFF to destination+1.
- R6: The result goes out as two writes in consecutive cycles. Bits 15:8 are written to the destination address and then bits 7:0 to destination+1.
- R7: `busy_o` is high from the cycle after start is accepted until the cycle of the second write. A start strobe while busy has no effect. Start is accepted only while `busy_o` is low.
- R8: `done_o` is high for exactly one cycle, in the cycle after the second write, and `busy_o` is low in that cycle.
- R9: For `n > 0`, the engine issues `m+1` reads in back-to-back cycles to addresses `a, a+1, ..., a+m`, and never reads and writes in the same cycle. `done_o` appears `m+5+(n&1)` cycles after the start edge. For `n = 0` it appears 3 cycles after the start edge.
- R10: For the standard block (start 0, count 0xF8, destination 0xFC), the two stored bytes equal the checksum defined by R2 to R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, sampled while idle |
| base_addr_i | input | AW | First byte address of the covered run |
| byte_cnt_i | input | CW | Number of bytes covered |
| dest_addr_i | input | AW | Address that receives the high result byte |
| busy_o | output | 1 | Engine is running |
| done_o | output | 1 | One-cycle completion pulse |
| mem_rd_en_o | output | 1 | Memory read request |
| mem_wr_en_o | output | 1 | Memory write request |
| mem_addr_o | output | AW | Shared memory address |
| mem_wr_data_o | output | 8 | Write byte |
| mem_rd_data_i | input | 8 | Read byte, valid one cycle after the request |

## Verification
A wrong fold or a wrong byte pairing in the running value stays hidden until the two result bytes are written. The stored pair then differs from the reference checksum, and every run over enough varied data exposes it at the end of the run. A wrong counter or sequencer state shows up much sooner, at the memory port. It appears as an extra or missing read, a write placed in the wrong cycle, or a `done_o` that comes early, late or for too long, and it is visible within a cycle or two of the faulty step. Odd counts, a count of one, a count of zero and a start strobe sent mid-run each drive a separate path through the sequencer.

// File: rtl/nvcrc_pkg.sv
package nvcrc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FETCH = 3'd1,
    ST_DRAIN = 3'd2,
    ST_TAIL  = 3'd3,
    ST_WR_HI = 3'd4,
    ST_WR_LO = 3'd5
  } nvcrc_state_e;

  localparam logic [15:0] CRC_SEED = 16'hFFFF;

endpackage

// File: rtl/nvcrc_step.sv
// One fold of the running checksum. Only the low byte of the word can reach
// the result, so only that byte enters this stage.
module nvcrc_step (
  input  logic [15:0] acc_i,
  input  logic [7:0]  lo_byte_i,
  output logic [15:0] acc_o
);
  logic [7:0]  mix;
  logic [15:0] nib_a;
  logic [15:0] nib_b;

  always_comb begin
    mix   = acc_i[7:0] ^ lo_byte_i;
    nib_a = {12'h000, mix[3:0]};
    nib_b = {12'h000, mix[7:4] ^ mix[3:0]};
    acc_o = {8'h00, acc_i[15:8]}
          ^ (nib_a << 3) ^ (nib_a << 8)
          ^ nib_b ^ (nib_b << 7) ^ (nib_b << 12);
  end
endmodule

// File: rtl/nvcrc_ctrl.sv
module nvcrc_ctrl
  import nvcrc_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] base_addr_i,
  input  logic [CW-1:0] byte_cnt_i,
  input  logic [AW-1:0] dest_addr_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          rd_en_o,
  output logic          wr_en_o,
  output logic [AW-1:0] addr_o,
  output logic          wr_hi_sel_o,
  output logic          load_seed_o,
  output logic          consume_o,
  output logic          first_o,
  output logic          tail_o
);
  localparam logic [CW-1:0] EVEN_MASK = {{(CW-1){1'b1}}, 1'b0};

  nvcrc_state_e  state_q, state_d;
  logic [AW-1:0] base_q, base_d;
  logic [AW-1:0] dest_q, dest_d;
  logic [CW-1:0] last_q, last_d;
  logic          odd_q, odd_d;
  logic [CW-1:0] iss_q, iss_d;
  logic          pend_q, pend_d;
  logic          first_q, first_d;
  logic          done_q, done_d;
  logic          accept;
  logic          iss_en;

  assign accept = (state_q == ST_IDLE) && start_i;
  assign iss_en = accept || (state_q == ST_FETCH);

  // next-state logic
  always_comb begin
    state_d     = state_q;
    base_d      = base_q;
    dest_d      = dest_q;
    last_d      = last_q;
    odd_d       = odd_q;
    iss_d       = iss_q;
    first_d     = first_q;
    rd_en_o     = 1'b0;
    wr_en_o     = 1'b0;
    wr_hi_sel_o = 1'b0;
    tail_o      = 1'b0;
    load_seed_o = 1'b0;
    addr_o      = base_q + AW'(iss_q);
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          base_d      = base_addr_i;
          dest_d      = dest_addr_i;
          last_d      = byte_cnt_i & EVEN_MASK;
          odd_d       = byte_cnt_i[0];
          iss_d       = '0;
          first_d     = 1'b1;
          load_seed_o = 1'b1;
          state_d     = (byte_cnt_i == '0) ? ST_WR_HI : ST_FETCH;
        end
      end
      ST_FETCH: begin
        rd_en_o = 1'b1;
        iss_d   = iss_q + 1'b1;
        if (iss_q == last_q) begin
          state_d = ST_DRAIN;
        end
      end
      ST_DRAIN: begin
        state_d = odd_q ? ST_TAIL : ST_WR_HI;
      end
      ST_TAIL: begin
        tail_o  = 1'b1;
        state_d = ST_WR_HI;
      end
      ST_WR_HI: begin
        wr_en_o     = 1'b1;
        wr_hi_sel_o = 1'b1;
        addr_o      = dest_q;
        state_d     = ST_WR_LO;
      end
      ST_WR_LO: begin
        wr_en_o = 1'b1;
        addr_o  = dest_q + 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
    if (pend_q) begin
      first_d = 1'b0;
    end
    pend_d = (state_q == ST_FETCH);
    done_d = (state_q == ST_WR_LO);
  end

  // state and pipeline flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b0;
      first_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      first_q <= first_d;
      done_q  <= done_d;
    end
  end

  // run parameters, loaded only on accept
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      dest_q <= '0;
      last_q <= '0;
      odd_q  <= 1'b0;
    end else if (accept) begin
      base_q <= base_d;
      dest_q <= dest_d;
      last_q <= last_d;
      odd_q  <= odd_d;
    end
  end

  // read index, advanced while fetching
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iss_q <= '0;
    end else if (iss_en) begin
      iss_q <= iss_d;
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign consume_o = pend_q;
  assign first_o   = first_q;
endmodule

// File: rtl/nvcrc_dp.sv
module nvcrc_dp
  import nvcrc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_seed_i,
  input  logic       consume_i,
  input  logic       first_i,
  input  logic       tail_i,
  input  logic       wr_hi_sel_i,
  input  logic [7:0] rd_data_i,
  output logic [7:0] wr_data_o
);
  logic [15:0] acc_q, acc_d;
  logic [15:0] acc_step;
  logic [7:0]  fold_byte;
  logic        fold_en;
  logic        acc_en;

  // tail fold: the low byte of the word is zero
  assign fold_byte = tail_i ? 8'h00 : rd_data_i;
  assign fold_en   = (consume_i && !first_i) || tail_i;
  assign acc_en    = load_seed_i || fold_en;

  nvcrc_step i_step (
    .acc_i     (acc_q),
    .lo_byte_i (fold_byte),
    .acc_o     (acc_step)
  );

  always_comb begin
    if (load_seed_i) begin
      acc_d = CRC_SEED;
    end else begin
      acc_d = acc_step;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= CRC_SEED;
    end else if (acc_en) begin
      acc_q <= acc_d;
    end
  end

  assign wr_data_o = wr_hi_sel_i ? acc_q[15:8] : acc_q[7:0];
endmodule

// File: rtl/nvcrc_engine.sv
module nvcrc_engine
  import nvcrc_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] base_addr_i,
  input  logic [CW-1:0] byte_cnt_i,
  input  logic [AW-1:0] dest_addr_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          mem_rd_en_o,
  output logic          mem_wr_en_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [7:0]    mem_wr_data_o,
  input  logic [7:0]    mem_rd_data_i
);
  logic wr_hi_sel;
  logic load_seed;
  logic consume;
  logic first;
  logic tail;

  nvcrc_ctrl #(.AW(AW), .CW(CW)) i_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .base_addr_i (base_addr_i),
    .byte_cnt_i  (byte_cnt_i),
    .dest_addr_i (dest_addr_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .rd_en_o     (mem_rd_en_o),
    .wr_en_o     (mem_wr_en_o),
    .addr_o      (mem_addr_o),
    .wr_hi_sel_o (wr_hi_sel),
    .load_seed_o (load_seed),
    .consume_o   (consume),
    .first_o     (first),
    .tail_o      (tail)
  );

  nvcrc_dp i_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_seed_i (load_seed),
    .consume_i   (consume),
    .first_i     (first),
    .tail_i      (tail),
    .wr_hi_sel_i (wr_hi_sel),
    .rd_data_i   (mem_rd_data_i),
    .wr_data_o   (mem_wr_data_o)
  );
endmodule

// File: rtl/nvcrc_engine_chk.sv
module nvcrc_engine_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          mem_rd_en_o,
  input logic          mem_wr_en_o,
  input logic [AW-1:0] mem_addr_o
);
  // R1: outputs quiet while in reset
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_quiet_in_reset: assert (!busy_o && !done_o && !mem_rd_en_o && !mem_wr_en_o)
        else $error("R1 outputs active in reset");
    end
  end

  // R8: done lasts a single cycle
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8: engine idle while done is shown
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  // R8: done follows a write
  a_r8_done_after_wr: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(mem_wr_en_o));

  // R6: second write lands on the next address in the next cycle
  a_r6_wr_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en_o && !$past(mem_wr_en_o)) |=>
      (mem_wr_en_o && mem_addr_o == $past(mem_addr_o) + 1'b1));

  // R9: never read and write together
  a_r9_no_rw_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en_o && mem_wr_en_o));

  // R9: consecutive reads walk upward by one
  a_r9_read_stride: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en_o && $past(mem_rd_en_o)) |-> mem_addr_o == $past(mem_addr_o) + 1'b1);

  // R7: memory activity only while busy
  a_r7_access_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en_o || mem_wr_en_o) |-> busy_o);

  // R7: a run only begins from a start strobe
  a_r7_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));
endmodule

bind nvcrc_engine nvcrc_engine_chk #(.AW(AW)) i_nvcrc_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .mem_rd_en_o (mem_rd_en_o),
  .mem_wr_en_o (mem_wr_en_o),
  .mem_addr_o  (mem_addr_o)
);

// File: tb/test_nvcrc_engine.sv
`timescale 1ns/1ps
module test_nvcrc_engine;
  localparam int AW = 16;
  localparam int CW = 16;
  localparam int NVEC = 7;

  // {base, count, dest}
  localparam logic [47:0] VEC [NVEC] = '{
    {16'h0000, 16'h00F8, 16'h00FC},
    {16'h0100, 16'h0002, 16'h01F0},
    {16'h0103, 16'h0005, 16'h01E0},
    {16'h0120, 16'h0001, 16'h01E2},
    {16'h0140, 16'h0000, 16'h01E4},
    {16'h0150, 16'h0003, 16'h01E6},
    {16'h0160, 16'h0021, 16'h01E8}
  };

  logic          clk;
  logic          rst_n;
  logic          start_i;
  logic [AW-1:0] base_addr_i;
  logic [CW-1:0] byte_cnt_i;
  logic [AW-1:0] dest_addr_i;
  logic          busy_o;
  logic          done_o;
  logic          mem_rd_en_o;
  logic          mem_wr_en_o;
  logic [AW-1:0] mem_addr_o;
  logic [7:0]    mem_wr_data_o;
  logic [7:0]    mem_rd_data_i;

  logic [7:0] mem [512];
  int rd_cnt, wr_cnt;
  logic [AW-1:0] wr_addr_log [2];
  int checks, errors;

  nvcrc_engine #(.AW(AW), .CW(CW)) i_nvcrc_engine (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .base_addr_i   (base_addr_i),
    .byte_cnt_i    (byte_cnt_i),
    .dest_addr_i   (dest_addr_i),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .mem_rd_en_o   (mem_rd_en_o),
    .mem_wr_en_o   (mem_wr_en_o),
    .mem_addr_o    (mem_addr_o),
    .mem_wr_data_o (mem_wr_data_o),
    .mem_rd_data_i (mem_rd_data_i)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // memory model with one-cycle read latency
  always @(posedge clk) begin
    if (mem_rd_en_o) begin
      mem_rd_data_i <= mem[mem_addr_o[8:0]];
      rd_cnt <= rd_cnt + 1;
    end
    if (mem_wr_en_o) begin
      mem[mem_addr_o[8:0]] <= mem_wr_data_o;
      if (wr_cnt < 2) wr_addr_log[wr_cnt] <= mem_addr_o;
      wr_cnt <= wr_cnt + 1;
    end
  end

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] fold(logic [15:0] c, logic [15:0] w);
    logic [15:0] x, a, b;
    x = c ^ w;
    a = x & 16'h000F;
    b = ((x >> 4) & 16'h000F) ^ a;
    return (c >> 8) ^ (a << 3) ^ (a << 8) ^ b ^ (b << 7) ^ (b << 12);
  endfunction

  function automatic logic [15:0] model_sum(int base, int cnt);
    logic [15:0] c;
    int m;
    c = 16'hFFFF;
    m = cnt & ~1;
    for (int i = 0; i < m; i++)
      c = fold(c, {mem[(base + i) & 511], mem[(base + i + 1) & 511]});
    if (cnt % 2 == 1)
      c = fold(c, {mem[(base + m) & 511], 8'h00});
    return c;
  endfunction

  // inject > 0: send a second start strobe in that cycle of the run
  task automatic run_case(input int base, input int cnt, input int dest, input int inject);
    logic [15:0] exp;
    int m, cyc, exp_lat, exp_rd;
    exp = model_sum(base, cnt);
    m = cnt & ~1;
    exp_rd = (cnt == 0) ? 0 : m + 1;
    exp_lat = (cnt == 0) ? 3 : m + 5 + (cnt % 2);
    @(negedge clk);
    rd_cnt = 0;
    wr_cnt = 0;
    base_addr_i = AW'(base);
    byte_cnt_i = CW'(cnt);
    dest_addr_i = AW'(dest);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    cyc = 1;
    while (!done_o && cyc < 5000) begin
      if (cyc == inject) begin
        base_addr_i = 16'h0000;
        byte_cnt_i = 16'h0000;
        dest_addr_i = 16'h01FA;
        start_i = 1'b1;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    start_i = 1'b0;
    check("R9", "done latency", cyc, exp_lat);
    check("R8", "busy low at done", busy_o, 0);
    check("R9", "read count", rd_cnt, exp_rd);
    check("R6", "write count", wr_cnt, 2);
    check("R6", "high byte address", wr_addr_log[0], dest);
    check("R6", "low byte address", wr_addr_log[1], dest + 1);
    check("R3", "stored high byte", mem[dest & 511], exp[15:8]);
    check("R4", "stored low byte", mem[(dest + 1) & 511], exp[7:0]);
    @(negedge clk);
    check("R8", "done single cycle", done_o, 0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    checks = 0;
    errors = 0;
    rd_cnt = 0;
    wr_cnt = 0;
    start_i = 1'b0;
    base_addr_i = '0;
    byte_cnt_i = '0;
    dest_addr_i = '0;
    for (int i = 0; i < 512; i++) mem[i] = 8'((i * 37 + 11) ^ (i >> 3));
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "busy in reset", busy_o, 0);
    check("R1", "done in reset", done_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "busy after reset", busy_o, 0);
    check("R1", "read enable after reset", mem_rd_en_o, 0);
    check("R1", "write enable after reset", mem_wr_en_o, 0);

    // table walk: R2 R3 R4 R5 R10 via stored results
    for (int v = 0; v < NVEC; v++) begin
      run_case(int'(VEC[v][47:32]), int'(VEC[v][31:16]), int'(VEC[v][15:0]), 0);
    end

    // R5: zero count leaves the seed
    check("R5", "zero count high byte", mem[9'h1E4], 8'hFF);
    check("R5", "zero count low byte", mem[9'h1E5], 8'hFF);

    // R10: standard block written at offset 0xFC
    check("R10", "standard block word", {mem[9'h0FC], mem[9'h0FD]}, model_sum(0, 16'hF8));

    // R2: count one folds a zero low byte into the seed
    check("R2", "count one value", {mem[9'h1E2], mem[9'h1E3]}, fold(16'hFFFF, 16'h0000));

    // R7: start strobe while busy is ignored
    begin
      logic [7:0] before_hi, before_lo;
      before_hi = mem[9'h1FA];
      before_lo = mem[9'h1FB];
      run_case(16'h0100, 16'h0010, 16'h01F8, 4);
      check("R7", "ignored start target high", mem[9'h1FA], before_hi);
      check("R7", "ignored start target low", mem[9'h1FB], before_lo);
      check("R7", "idle after run", busy_o, 0);
    end

    // back-to-back run right after done
    run_case(16'h0011, 16'h0007, 16'h01D0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule